// File: doc/BRIEF.md
# Two-Tap Video Frame Timing Generator

This block produces a parallel camera-style video stream. On every rising clock edge it presents one beat made of two pixel taps and two framing flags: a frame flag that brackets the whole image and a line flag that brackets each row of pixels. Pixels are sent row by row, starting at the top-left pixel and ending at the bottom-right pixel. The earlier pixel of each horizontal pair goes on tap 0 and the later one on tap 1. Pixel values come from an internal 10-bit test pattern. The bench can predict every sample of that pattern, so the stream doubles as a link and capture self-test.

Image width, image height, the gap between lines and the gap between frames are set at runtime, up to fixed maximums. A depth control selects full 10-bit samples or only the upper 8 bits of each sample. New geometry and depth settings take effect only when a new frame starts. The frame gap is read live. Deasserting `enable` lets the current frame finish and then holds the stream idle.

Top module: `dual_tap_vidgen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `fval`, `lval`, `tap0` and `tap1` are all zero.
- R2: `lval` is high only while `fval` is high. Whenever `lval` is low, both taps are driven to zero.
- R3: The first `lval` of a frame rises exactly 24 clocks after `fval` rises. During those 24 clocks `fval` is high and `lval` is low.
- R4: Each line keeps `lval` high for W/2 consecutive clocks and then drops it. W is `cfg_width` with bit 0 forced to 0, clamped to the range 2 to MAX_WIDTH (2352), so a full-width line lasts 1176 clocks.
- R5: A frame carries H lines, where H is `cfg_height` clamped to the range 1 to MAX_HEIGHT. `fval` drops on the clock right after the last beat of the last line.
- R6: Between two lines of one frame, `lval` stays low for exactly `cfg_hblank` clocks while `fval` stays high. A value of 0 acts as 1.
- R7: With `enable` held high, `fval` stays low for exactly `cfg_vblank` clocks between frames, and a value of 0 acts as 1. The value in force is the one present while `fval` is low.
- R8: On beat k of row y (both counted from 0) of frame f (counted from 0 after reset, modulo 256), tap0 carries pixel x=2k and tap1 carries pixel x=2k+1. Pixel value P(x,y,f) = (x + 4*y + 37*f) mod 1024.
- R9: With `cfg_narrow`=0 each tap carries P in full. With `cfg_narrow`=1 each tap carries P>>2 in bits [7:0], and bits [9:8] are zero.
- R10: Width, height, line gap and depth are sampled only when a frame starts. Changing them while `fval` is high has no effect on that frame.
- R11: While `enable` is low no new frame starts: `fval` stays low once the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new frames to start |
| cfg_width | input | WIDTH_W (12) | Requested pixels per line |
| cfg_height | input | HEIGHT_W (11) | Requested lines per frame |
| cfg_hblank | input | BLANK_W (12) | Line-gap length in clocks |
| cfg_vblank | input | BLANK_W (12) | Frame-gap length in clocks |
| cfg_narrow | input | 1 | 1 selects 8-bit output per tap |
| fval | output | 1 | Frame flag |
| lval | output | 1 | Line flag |
| tap0 | output | PIX_W (10) | Earlier pixel of the pair |
| tap1 | output | PIX_W (10) | Later pixel of the pair |

## Verification
The bench builds the block with its default parameters: a 2352-pixel maximum width, a 1726-line maximum height, 10-bit pixels, 8-bit narrow output and a 24-clock lead. With these values it can run a single full-width line of 1176 beats, clamp a width request of 3000 down to that maximum, and exercise the minimum-width clamp from a request of 0. Heights are kept small so that many randomly shaped frames fit in the run, each with its own gaps and depth. The frame counter runs past several values, which varies the pattern offset from frame to frame.

// File: rtl/vg_pkg.sv
package vg_pkg;

  typedef enum logic [1:0] {
    ST_VBLANK = 2'd0,
    ST_LEAD   = 2'd1,
    ST_LINE   = 2'd2,
    ST_HBLANK = 2'd3
  } vg_state_e;

  // Test pattern: column, row and frame offsets summed; caller keeps the low bits.
  function automatic logic [15:0] vg_pixel(input logic [15:0] x,
                                           input logic [15:0] y,
                                           input logic [15:0] f);
    logic [15:0] acc;
    acc = x + (y << 2) + (f * 16'd37);
    return acc;
  endfunction

  // Larger of two ints, used for counter sizing.
  function automatic int vg_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vg_cfg_latch.sv
module vg_cfg_latch #(
  parameter int MAX_WIDTH  = 2352,
  parameter int MAX_HEIGHT = 1726,
  parameter int WIDTH_W    = 12,
  parameter int HEIGHT_W   = 11,
  parameter int HALF_W     = 11,
  parameter int BLANK_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WIDTH_W-1:0]  in_width,
  input  logic [HEIGHT_W-1:0] in_height,
  input  logic [BLANK_W-1:0]  in_hblank,
  input  logic                in_narrow,
  output logic [HALF_W-1:0]   half_w,
  output logic [HEIGHT_W-1:0] height,
  output logic [BLANK_W-1:0]  hblank,
  output logic                narrow
);

  logic [WIDTH_W-1:0]  w_even, w_san;
  logic [HEIGHT_W-1:0] h_san;
  logic [BLANK_W-1:0]  hb_san;

  always_comb begin
    w_even = in_width & ~WIDTH_W'(1);
    if (w_even < WIDTH_W'(2))              w_san = WIDTH_W'(2);
    else if (w_even > WIDTH_W'(MAX_WIDTH)) w_san = WIDTH_W'(MAX_WIDTH);
    else                                   w_san = w_even;

    if (in_height == '0)                       h_san = HEIGHT_W'(1);
    else if (in_height > HEIGHT_W'(MAX_HEIGHT)) h_san = HEIGHT_W'(MAX_HEIGHT);
    else                                        h_san = in_height;

    hb_san = (in_hblank == '0) ? BLANK_W'(1) : in_hblank;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_w <= HALF_W'(1);
      height <= HEIGHT_W'(1);
      hblank <= BLANK_W'(1);
      narrow <= 1'b0;
    end else if (load) begin
      half_w <= HALF_W'(w_san >> 1);
      height <= h_san;
      hblank <= hb_san;
      narrow <= in_narrow;
    end
  end

  // Sanitised geometry never leaves its legal window.
  assert_half_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_w != '0) && (half_w <= HALF_W'(MAX_WIDTH / 2)));
  assert_height_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (height != '0) && (height <= HEIGHT_W'(MAX_HEIGHT)));
  assert_hblank_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hblank != '0);

endmodule

// File: rtl/vg_timing.sv
module vg_timing
  import vg_pkg::*;
#(
  parameter int LEAD_CYC = 24,
  parameter int HALF_W   = 11,
  parameter int HEIGHT_W = 11,
  parameter int BLANK_W  = 12,
  parameter int FRAME_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [BLANK_W-1:0]  vblank_len,
  input  logic [HALF_W-1:0]   half_w,
  input  logic [HEIGHT_W-1:0] height,
  input  logic [BLANK_W-1:0]  hblank,
  output logic                fval,
  output logic                lval,
  output logic [HALF_W-1:0]   col,
  output logic [HEIGHT_W-1:0] row,
  output logic [FRAME_W-1:0]  frame_idx,
  output logic                frame_start
);

  localparam int LEAD_W = $clog2(LEAD_CYC) + 1;
  localparam int CNT_W  = vg_max(vg_max(BLANK_W, HALF_W), LEAD_W);

  vg_state_e            state_q, state_nx;
  logic [CNT_W-1:0]     tick_q, tick_nx;
  logic [HEIGHT_W-1:0]  row_q;
  logic [FRAME_W-1:0]   frame_q;
  logic [BLANK_W-1:0]   vb_len;

  // Named internal events
  logic vb_done, lead_done, line_done, hb_done, last_row, line_end;

  always_comb begin
    vb_len    = (vblank_len == '0) ? BLANK_W'(1) : vblank_len;
    vb_done   = tick_q >= (CNT_W'(vb_len) - CNT_W'(1));
    lead_done = tick_q == CNT_W'(LEAD_CYC - 1);
    line_done = tick_q == (CNT_W'(half_w) - CNT_W'(1));
    hb_done   = tick_q == (CNT_W'(hblank) - CNT_W'(1));
    last_row  = row_q == (height - HEIGHT_W'(1));
    frame_start = (state_q == ST_VBLANK) && enable && vb_done;
    line_end    = (state_q == ST_LINE) && line_done;
  end

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_VBLANK: if (frame_start) state_nx = ST_LEAD;
      ST_LEAD:   if (lead_done)   state_nx = ST_LINE;
      ST_LINE:   if (line_done)   state_nx = last_row ? ST_VBLANK : ST_HBLANK;
      ST_HBLANK: if (hb_done)     state_nx = ST_LINE;
      default:                    state_nx = ST_VBLANK;
    endcase
  end

  always_comb begin
    if (state_nx != state_q)    tick_nx = '0;
    else if (tick_q != '1)      tick_nx = tick_q + CNT_W'(1);
    else                        tick_nx = tick_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_VBLANK;
      tick_q  <= '0;
      row_q   <= '0;
      frame_q <= '0;
    end else begin
      state_q <= state_nx;
      tick_q  <= tick_nx;
      if (frame_start)
        row_q <= '0;
      else if (line_end && !last_row)
        row_q <= row_q + HEIGHT_W'(1);
      if (line_end && last_row)
        frame_q <= frame_q + FRAME_W'(1);
    end
  end

  assign fval      = (state_q != ST_VBLANK);
  assign lval      = (state_q == ST_LINE);
  assign col       = HALF_W'(tick_q);
  assign row       = row_q;
  assign frame_idx = frame_q;

  // Age of the frame flag, kept for the lead-time check.
  logic [LEAD_W:0] fv_age_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !fval)      fv_age_q <= '0;
    else if (fv_age_q != '1)  fv_age_q <= fv_age_q + 1'b1;
  end

  assert_lval_in_fval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lval |-> fval);
  assert_lead_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lval) && row == '0) |-> (fv_age_q == (LEAD_W+1)'(LEAD_CYC)));
  assert_line_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lval && col == (half_w - HALF_W'(1))) |=> !lval);
  assert_fval_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fval) |-> $past(lval));
  assert_row_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fval |-> (row < height));
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fval && $past(fval)) |-> ($stable(half_w) && $stable(height) && $stable(hblank)));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fval && !enable) |=> !fval);

endmodule

// File: rtl/vg_pattern.sv
module vg_pattern
  import vg_pkg::*;
#(
  parameter int NTAPS    = 2,
  parameter int HALF_W   = 11,
  parameter int HEIGHT_W = 11,
  parameter int FRAME_W  = 8,
  parameter int PIX_W    = 10
) (
  input  logic [HALF_W-1:0]             col,
  input  logic [HEIGHT_W-1:0]           row,
  input  logic [FRAME_W-1:0]            frame_idx,
  output logic [NTAPS-1:0][PIX_W-1:0]   pix
);

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    logic [15:0] x;
    logic [15:0] val;
    assign x   = 16'(col) * 16'(NTAPS) + 16'(t);
    assign val = vg_pixel(x, 16'(row), 16'(frame_idx));
    assign pix[t] = val[PIX_W-1:0];
  end

endmodule

// File: rtl/vg_tap_fmt.sv
module vg_tap_fmt #(
  parameter int NTAPS = 2,
  parameter int PIX_W = 10,
  parameter int OUT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lval,
  input  logic                          narrow,
  input  logic [NTAPS-1:0][PIX_W-1:0]   pix_in,
  output logic [NTAPS-1:0][PIX_W-1:0]   tap_out
);

  localparam int DROP = PIX_W - OUT_W;

  for (genvar t = 0; t < NTAPS; t++) begin : g_fmt
    logic [PIX_W-1:0] shrunk;
    assign shrunk = pix_in[t] >> DROP;
    assign tap_out[t] = !lval ? '0 : (narrow ? shrunk : pix_in[t]);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lval |-> (tap_out[t] == '0));
    assert_narrow_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |-> (tap_out[t][PIX_W-1:OUT_W] == '0));
    assert_wide_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lval && !narrow) |-> (tap_out[t] == pix_in[t]));
  end

endmodule

// File: rtl/dual_tap_vidgen.sv
module dual_tap_vidgen #(
  parameter int MAX_WIDTH  = 2352,
  parameter int MAX_HEIGHT = 1726,
  parameter int PIX_W      = 10,
  parameter int OUT_W      = 8,
  parameter int LEAD_CYC   = 24,
  parameter int BLANK_W    = 12,
  parameter int FRAME_W    = 8,
  parameter int WIDTH_W    = $clog2(MAX_WIDTH + 1),
  parameter int HEIGHT_W   = $clog2(MAX_HEIGHT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [WIDTH_W-1:0]  cfg_width,
  input  logic [HEIGHT_W-1:0] cfg_height,
  input  logic [BLANK_W-1:0]  cfg_hblank,
  input  logic [BLANK_W-1:0]  cfg_vblank,
  input  logic                cfg_narrow,
  output logic                fval,
  output logic                lval,
  output logic [PIX_W-1:0]    tap0,
  output logic [PIX_W-1:0]    tap1
);

  localparam int NTAPS  = 2;
  localparam int HALF_W = $clog2(MAX_WIDTH / NTAPS + 1);

  logic                         frame_start;
  logic [HALF_W-1:0]            half_w, col;
  logic [HEIGHT_W-1:0]          height, row;
  logic [BLANK_W-1:0]           hblank;
  logic                         narrow;
  logic [FRAME_W-1:0]           frame_idx;
  logic [NTAPS-1:0][PIX_W-1:0]  pix, taps;

  vg_cfg_latch #(
    .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT), .WIDTH_W(WIDTH_W),
    .HEIGHT_W(HEIGHT_W), .HALF_W(HALF_W), .BLANK_W(BLANK_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .in_width(cfg_width), .in_height(cfg_height), .in_hblank(cfg_hblank),
    .in_narrow(cfg_narrow),
    .half_w(half_w), .height(height), .hblank(hblank), .narrow(narrow)
  );

  vg_timing #(
    .LEAD_CYC(LEAD_CYC), .HALF_W(HALF_W), .HEIGHT_W(HEIGHT_W),
    .BLANK_W(BLANK_W), .FRAME_W(FRAME_W)
  ) timing_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .vblank_len(cfg_vblank),
    .half_w(half_w), .height(height), .hblank(hblank),
    .fval(fval), .lval(lval), .col(col), .row(row),
    .frame_idx(frame_idx), .frame_start(frame_start)
  );

  vg_pattern #(
    .NTAPS(NTAPS), .HALF_W(HALF_W), .HEIGHT_W(HEIGHT_W),
    .FRAME_W(FRAME_W), .PIX_W(PIX_W)
  ) pattern_i (
    .col(col), .row(row), .frame_idx(frame_idx), .pix(pix)
  );

  vg_tap_fmt #(
    .NTAPS(NTAPS), .PIX_W(PIX_W), .OUT_W(OUT_W)
  ) fmt_i (
    .clk(clk), .rst_n(rst_n), .lval(lval), .narrow(narrow),
    .pix_in(pix), .tap_out(taps)
  );

  assign tap0 = taps[0];
  assign tap1 = taps[1];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!fval && !lval && tap0 == '0 && tap1 == '0));

endmodule

// File: tb/dual_tap_vidgen_tb.sv
`timescale 1ns/1ps
module dual_tap_vidgen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [11:0] cfg_width = '0;
  logic [10:0] cfg_height = '0;
  logic [11:0] cfg_hblank = '0;
  logic [11:0] cfg_vblank = '0;
  logic        cfg_narrow = 1'b0;
  logic        fval, lval;
  logic [9:0]  tap0, tap1;

  int checks = 0;
  int fails  = 0;
  int fidx   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_tap_vidgen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank), .cfg_narrow(cfg_narrow),
    .fval(fval), .lval(lval), .tap0(tap0), .tap1(tap1)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_w(input int w);
    int e = (w / 2) * 2;
    if (e < 2) e = 2;
    if (e > 2352) e = 2352;
    return e;
  endfunction

  function automatic int eff_h(input int h);
    return (h == 0) ? 1 : ((h > 1726) ? 1726 : h);
  endfunction

  function automatic int at_least1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int expect_pix(input int x, input int y, input int f, input bit m8);
    int p = (x + 4 * y + 37 * (f % 256)) % 1024;
    return m8 ? (p / 4) : p;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  // Entry: at a negedge where fval has just become high.
  task automatic check_frame(input int w, input int h, input int hb, input bit m8,
                             input int nw, input int nh, input int nhb, input int nvb,
                             input bit nm8, input bit nen);
    int ew = eff_w(w);
    int eh = eff_h(h);
    int ehb = at_least1(hb);
    int n;
    // Next settings go in now, in mid-frame (R10: this frame must not see them).
    cfg_width = 12'(nw); cfg_height = 11'(nh); cfg_hblank = 12'(nhb);
    cfg_vblank = 12'(nvb); cfg_narrow = nm8; enable = nen;
    n = 0;
    while (!lval && fval && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 24, "R3", "lead clocks", n, 24);
    for (int y = 0; y < eh; y++) begin
      for (int k = 0; k < ew / 2; k++) begin
        chk(fval && lval, "R4", "lval during line", int'(lval), 1);
        chk(int'(tap0) == expect_pix(2 * k, y, fidx, m8), m8 ? "R9" : "R8",
            "tap0", int'(tap0), expect_pix(2 * k, y, fidx, m8));
        chk(int'(tap1) == expect_pix(2 * k + 1, y, fidx, m8), m8 ? "R9" : "R8",
            "tap1", int'(tap1), expect_pix(2 * k + 1, y, fidx, m8));
        @(negedge clk);
      end
      chk(!lval, "R4", "lval after line", int'(lval), 0);
      if (y < eh - 1) begin
        n = 0;
        while (!lval && fval && n < 5000) begin
          chk(tap0 == 0 && tap1 == 0, "R2", "taps in line gap", int'(tap0) + int'(tap1), 0);
          n++;
          @(negedge clk);
        end
        chk(fval == 1'b1, "R6", "fval in line gap", int'(fval), 1);
        chk(n == ehb, "R6", "line gap clocks", n, ehb);
      end else begin
        chk(!fval, "R5", "fval after last line", int'(fval), 0);
      end
    end
    fidx++;
    if (nen) begin
      n = 0;
      while (!fval && n < 10000) begin
        chk(!lval && tap0 == 0 && tap1 == 0, "R2", "idle outputs",
            int'(lval) + int'(tap0), 0);
        n++;
        @(negedge clk);
      end
      chk(n == at_least1(nvb), "R7", "frame gap clocks", n, at_least1(nvb));
    end else begin
      for (int i = 0; i < 300; i++) begin
        chk(!fval && !lval, "R11", "stays idle", int'(fval), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int cw, ch, chb, cm;
    int nw, nh, nhb, nvb, nm;
    int n;
    void'($urandom(32'h1DEA5));
    cfg_width = 12'd8; cfg_height = 11'd3; cfg_hblank = 12'd2;
    cfg_vblank = 12'd3; cfg_narrow = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!fval && !lval && tap0 == 0 && tap1 == 0, "R1", "in reset",
        int'(fval) + int'(tap0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fval && !lval && tap0 == 0 && tap1 == 0, "R1", "after reset",
        int'(fval) + int'(tap0), 0);
    for (int i = 0; i < 30; i++) begin
      chk(!fval, "R11", "no frame while disabled", int'(fval), 0);
      @(negedge clk);
    end
    enable = 1'b1;
    n = 0;
    while (!fval && n < 1000) begin
      n++;
      @(negedge clk);
    end
    // Directed: mid-frame change of width, height and depth (R10).
    check_frame(8, 3, 2, 0, 6, 2, 3, 4, 1, 1);
    // Odd width and zero gaps (R4, R6, R7).
    check_frame(6, 2, 3, 1, 7, 2, 0, 0, 0, 1);
    // Over-maximum width clamps to a 1176-beat line (R4).
    check_frame(7, 2, 0, 0, 3000, 1, 1, 3, 1, 1);
    // Zero width and height clamp to minimum (R4, R5).
    check_frame(3000, 1, 1, 1, 0, 0, 1, 2, 0, 1);
    cw = 0; ch = 0; chb = 1; cm = 0;
    for (int r = 0; r < 10; r++) begin
      nw  = $urandom_range(40, 0);
      nh  = $urandom_range(5, 1);
      nhb = $urandom_range(6, 0);
      nvb = $urandom_range(6, 0);
      nm  = $urandom_range(1, 0);
      check_frame(cw, ch, chb, cm[0], nw, nh, nhb, nvb, nm[0], 1'b1);
      cw = nw; ch = nh; chb = nhb; cm = nm;
    end
    // Final frame with enable dropped mid-frame (R11).
    check_frame(cw, ch, chb, cm[0], 10, 2, 1, 1, 0, 1'b0);
    summary();
    $finish;
  end

endmodule